// File: doc/BRIEF.md
# SPI Slave Core with Watermark Ready Throttling

This block is the target end of an SPI link. The pins are serial clock, data in, data out, an active-low select and an active-high ready. Its system side has two FIFOs. Incoming words collect in a receive FIFO, which the system drains through a pop port while a request line is high. Outgoing words are pushed into a transmit FIFO. A request line asks for more transmit data while that FIFO has room. Clock polarity and clock phase are control inputs. With phase 0, the first data bit is presented as soon as select falls. With phase 1, it is presented on the first active clock edge.

Ready lets the core hold off the master. When flow control is on, ready drops once the receive FIFO reaches a programmable fill level and rises again as the system drains it. When flow control is off, ready stays high, and a policy input decides what happens to a word that arrives at a full receive FIFO: it is either dropped or written over the newest entry. A receive overflow sets a sticky flag, and so does a transmit underrun. Each flag is cleared by a one-cycle clear pulse. The serial pins are brought into the system clock through two-flop synchronizers, and clock edges are detected there. The system clock must therefore run at least four times faster than the serial clock.

Top module: `spi_slv_rdy`

## Requirements
- R1: Words are 8 bits and travel MSB first. With phase 0, data out shows the MSB once select is low, data in is sampled on the leading clock edge, and data out changes on the trailing edge. With phase 1, data out changes on the leading edge and data in is sampled on the trailing edge. The leading edge is rising when polarity is 0 and falling when it is 1.
- R2: While select stays low, words follow one another without a gap. A word cut short when select rises is not stored.
- R3: With receive enabled, every completed word enters the receive FIFO. With receive disabled, completed words are dropped and no flag is set.
- R4: The receive request is high exactly when receive is enabled and the receive FIFO holds at least one word. The receive data port shows the oldest word, and a pop removes it.
- R5: With flow control on, ready is low while the receive FIFO holds at least watermark+1 words, with a watermark of 0 to 3 on a 4-deep FIFO. Ready is high whenever the FIFO holds fewer.
- R6: With flow control off, ready is always high.
- R7: A word that completes while the receive FIFO is full and no pop happens in that cycle is an overflow. With flow control on, or with the policy input at 0, the word is dropped. With flow control off and the policy at 1, it replaces the newest entry.
- R8: The overflow flag stays set until a clear pulse arrives. A new overflow in the same cycle as the clear wins.
- R9: The transmit request equals transmit-enable AND transmit FIFO not full. A push into a full transmit FIFO is ignored.
- R10: Each word started with transmit enabled consumes one transmit entry. If the transmit FIFO is empty, the word is sent as zeros and the sticky underrun flag is set until its clear pulse. With transmit disabled, the word is sent as zeros, no flag is set and the transmit FIFO is left untouched.
- R11: Data out is 0 while select is high.
- R12: After reset, both flags are 0, the receive request is 0, ready is 1 and the transmit request equals transmit-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| rdy | output | 1 | Active-high ready to the master |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| rx_en | input | 1 | Receive path enable |
| tx_en | input | 1 | Transmit path enable |
| fc_en | input | 1 | Ready-based flow control enable |
| wmark | input | 2 | Receive fill threshold minus one |
| ovf_pol | input | 1 | Full-FIFO policy: 0 drop, 1 overwrite newest |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 8 | Oldest received word |
| rx_req | output | 1 | Receive data available |
| tx_push | input | 1 | Store a word for transmission |
| tx_data | input | 8 | Word to transmit |
| tx_req | output | 1 | Transmit FIFO can take data |
| ovf_flag | output | 1 | Sticky receive overflow |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| udr_flag | output | 1 | Sticky transmit underrun |
| udr_clr | input | 1 | Clear pulse for the underrun flag |

## Verification
A corrupted receive count shows up at once at the ports. Ready and the receive request move at the wrong level from the next system clock on, long before any data is lost. A wrong receive pointer appears on the data port the first time the system pops after the fault. A transmit pointer or a bit counter that slips garbles the next word the master samples, so the fault is visible within one word time. Missing overwrite or discard handling leaves an extra or a wrong entry, which the next sequence of pops exposes.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef enum logic {
    FULL_DROP      = 1'b0,
    FULL_OVERWRITE = 1'b1
  } full_policy_e;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[s] <= RST_VAL;
        else        st_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[s] <= RST_VAL;
        else        st_q[s] <= st_q[s-1];
      end
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_slv_fifo.sv
module spi_slv_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          ovw,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [AW:0]   count
);
  localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n, waddr;
  logic [AW:0]   cnt_q, cnt_n;
  logic          empty, full, do_pop, do_push, do_ovw, we;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == FULL_V);
    do_pop  = pop & ~empty;
    do_push = push & (~full | do_pop);
    do_ovw  = ovw & full & ~do_pop;
    we      = do_push | do_ovw;
    waddr   = do_ovw ? (wp_q - 1'b1) : wp_q;
    wp_n    = wp_q + AW'(do_push);
    rp_n    = rp_q + AW'(do_pop);
    cnt_n   = cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          ss_n_s,
  input  logic          mosi_s,
  input  logic          tx_en,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_head,
  output logic          miso,
  output logic          tx_take,
  output logic          udr_set,
  output logic          rx_done,
  output logic [DW-1:0] rx_word
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_d, ssa_d, need_q, need_n;
  logic [CW-1:0] bit_q, bit_n;
  logic [DW-1:0] txsh_q, txsh_n, rxsh_q, rxsh_n, peek;
  logic          ss_act, ss_fall, rise, fall, lead, trail;
  logic          drv_e, smp_e, first, last, commit;

  always_comb begin
    ss_act  = ~ss_n_s;
    ss_fall = ss_act & ~ssa_d;
    rise    = sck_s & ~sck_d;
    fall    = ~sck_s & sck_d;
    lead    = cpol ? fall : rise;
    trail   = cpol ? rise : fall;
    drv_e   = ss_act & (cpha ? lead : trail);
    smp_e   = ss_act & (cpha ? trail : lead);
    first   = (bit_q == '0);
    last    = (bit_q == LAST);
    peek    = tx_avail ? tx_head : '0;
    commit  = first & (cpha ? drv_e : smp_e);
    tx_take = commit & tx_avail;
    udr_set = commit & tx_en & ~tx_avail;
    rx_word = {rxsh_q[DW-2:0], mosi_s};
    rx_done = smp_e & last;

    bit_n  = bit_q;
    need_n = need_q;
    txsh_n = txsh_q;
    rxsh_n = rxsh_q;
    if (!ss_act) begin
      bit_n  = '0;
      need_n = 1'b0;
    end else begin
      if (ss_fall && !cpha) txsh_n = peek;
      if (drv_e) begin
        if (cpha ? first : need_q) begin
          txsh_n = peek;
          need_n = 1'b0;
        end else begin
          txsh_n = txsh_q << 1;
        end
      end
      if (smp_e) begin
        rxsh_n = rx_word;
        if (last) begin
          bit_n  = '0;
          need_n = ~cpha;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      ssa_d  <= 1'b0;
      need_q <= 1'b0;
      bit_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      sck_d  <= sck_s;
      ssa_d  <= ss_act;
      need_q <= need_n;
      bit_q  <= bit_n;
      txsh_q <= txsh_n;
      rxsh_q <= rxsh_n;
    end
  end

  assign miso = ss_act & txsh_q[DW-1];
endmodule

// File: rtl/spi_slv_rdy.sv
module spi_slv_rdy #(
  parameter int DW = 8,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int RX_AW = $clog2(RX_DEPTH),
  localparam int TX_AW = $clog2(TX_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             ss_n,
  input  logic             mosi,
  output logic             miso,
  output logic             rdy,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             fc_en,
  input  logic [RX_AW-1:0] wmark,
  input  logic             ovf_pol,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data,
  output logic             rx_req,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_req,
  output logic             ovf_flag,
  input  logic             ovf_clr,
  output logic             udr_flag,
  input  logic             udr_clr
);
  import spi_slv_pkg::*;

  localparam logic [RX_AW:0] RX_FULL = (RX_AW+1)'(RX_DEPTH);
  localparam logic [TX_AW:0] TX_FULL = (TX_AW+1)'(TX_DEPTH);

  logic [1:0]      rs_q;
  logic            rst_i_n;
  logic [2:0]      pins_s;
  logic            ss_n_s, sck_s, mosi_s;
  logic [RX_AW:0]  rx_cnt;
  logic [TX_AW:0]  tx_cnt;
  logic [DW-1:0]   tx_head, rx_word;
  logic            tx_avail, tx_take, udr_set, rx_done;
  logic            rx_push, rx_ovw, rx_full, ovf_set;
  logic            ovf_q, ovf_n, udr_q, udr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({ss_n, sck, mosi}), .q(pins_s)
  );
  assign {ss_n_s, sck_s, mosi_s} = pins_s;

  spi_slv_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .cpol(cpol), .cpha(cpha),
    .sck_s(sck_s), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
    .tx_en(tx_en), .tx_avail(tx_avail), .tx_head(tx_head),
    .miso(miso), .tx_take(tx_take), .udr_set(udr_set),
    .rx_done(rx_done), .rx_word(rx_word)
  );

  spi_slv_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_i_n), .push(tx_push), .ovw(1'b0), .pop(tx_take),
    .din(tx_data), .dout(tx_head), .count(tx_cnt)
  );

  spi_slv_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_i_n), .push(rx_push), .ovw(rx_ovw), .pop(rx_pop),
    .din(rx_word), .dout(rx_data), .count(rx_cnt)
  );

  always_comb begin
    tx_avail = tx_en & (tx_cnt != '0);
    tx_req   = tx_en & (tx_cnt != TX_FULL);
    rx_full  = (rx_cnt == RX_FULL);
    rx_push  = rx_done & rx_en;
    rx_ovw   = rx_push & ~fc_en & (full_policy_e'(ovf_pol) == FULL_OVERWRITE);
    ovf_set  = rx_push & rx_full & ~rx_pop;
    rx_req   = rx_en & (rx_cnt != '0);
    rdy      = fc_en ? (rx_cnt <= {1'b0, wmark}) : 1'b1;
    ovf_n    = ovf_set | (ovf_q & ~ovf_clr);
    udr_n    = udr_set | (udr_q & ~udr_clr);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ovf_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_n;
      udr_q <= udr_n;
    end
  end

  assign ovf_flag = ovf_q;
  assign udr_flag = udr_q;
endmodule

// File: rtl/spi_slv_rdy_chk.sv
module spi_slv_rdy_chk #(
  parameter int CNT_W = 3,
  parameter int RX_DEPTH = 4
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             ss_n_s,
  input logic             miso,
  input logic             rdy,
  input logic             fc_en,
  input logic             rx_en,
  input logic             rx_req,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             udr_flag,
  input logic             udr_clr
);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R10
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (udr_flag && !udr_clr) |=> udr_flag);

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ss_n_s |-> !miso);

  // R5
  rdy_req_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fc_en && !rdy && rx_en) |-> rx_req);

  // R4
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rx_cnt <= CNT_W'(RX_DEPTH));
endmodule

bind spi_slv_rdy spi_slv_rdy_chk #(.CNT_W(RX_AW + 1), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .ss_n_s(ss_n_s), .miso(miso), .rdy(rdy),
  .fc_en(fc_en), .rx_en(rx_en), .rx_req(rx_req), .rx_cnt(rx_cnt),
  .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .udr_flag(udr_flag), .udr_clr(udr_clr)
);

// File: tb/spi_slv_rdy_tb.sv
`timescale 1ns/1ps
module spi_slv_rdy_tb;
  localparam int H = 8;

  logic clk, rst_n, sck, ss_n, mosi, miso, rdy;
  logic cpol, cpha, rx_en, tx_en, fc_en, ovf_pol;
  logic [1:0] wmark;
  logic rx_pop, rx_req, tx_push, tx_req, ovf_flag, ovf_clr, udr_flag, udr_clr;
  logic [7:0] rx_data, tx_data;

  int errors = 0, checks = 0, wseed = 0;
  bit cmp_en = 0, done = 0;
  logic [7:0] rxq[$], txq[$];
  bit m_ovf = 0, m_udr = 0;

  spi_slv_rdy u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .rdy(rdy), .cpol(cpol), .cpha(cpha), .rx_en(rx_en), .tx_en(tx_en),
    .fc_en(fc_en), .wmark(wmark), .ovf_pol(ovf_pol), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_req(rx_req), .tx_push(tx_push), .tx_data(tx_data),
    .tx_req(tx_req), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .udr_flag(udr_flag), .udr_clr(udr_clr)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  // Reference model compared on every clock while no frame is in flight
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R4", "rx_req", {7'd0, rx_req}, {7'd0, rx_en && rxq.size() > 0});
      check(fc_en ? "R5" : "R6", "rdy", {7'd0, rdy},
            {7'd0, !fc_en || (rxq.size() <= int'(wmark))});
      check("R9", "tx_req", {7'd0, tx_req}, {7'd0, tx_en && txq.size() < 4});
      check("R8", "ovf_flag", {7'd0, ovf_flag}, {7'd0, m_ovf});
      check("R10", "udr_flag", {7'd0, udr_flag}, {7'd0, m_udr});
      check("R11", "miso idle", {7'd0, miso}, 8'd0);
      if (rxq.size() > 0) check("R4", "rx_data", rx_data, rxq[0]);
    end
  end

  function automatic logic [7:0] model_tx_load();
    if (!tx_en) return 8'd0;
    if (txq.size() > 0) return txq.pop_front();
    m_udr = 1;
    return 8'd0;
  endfunction

  function automatic void model_rx_word(input logic [7:0] w);
    if (!rx_en) return;
    if (rxq.size() < 4) rxq.push_back(w);
    else begin
      m_ovf = 1;
      if (!fc_en && ovf_pol) rxq[rxq.size()-1] = w;
    end
  endfunction

  task automatic push_tx(input logic [7:0] d);
    @(posedge clk); #1 tx_push = 1; tx_data = d;
    @(posedge clk); #1 tx_push = 0;
    if (txq.size() < 4) txq.push_back(d);
  endtask

  task automatic pop_rx();
    @(posedge clk); #1 rx_pop = 1;
    @(posedge clk); #1 rx_pop = 0;
    if (rxq.size() > 0) void'(rxq.pop_front());
  endtask

  task automatic clr_flags(input bit o, input bit u);
    @(posedge clk); #1 ovf_clr = o; udr_clr = u;
    @(posedge clk); #1 ovf_clr = 0; udr_clr = 0;
    if (o) m_ovf = 0;
    if (u) m_udr = 0;
  endtask

  task automatic set_mode(input logic p, input logic h);
    @(posedge clk); #1 cpol = p; cpha = h; sck = p;
    repeat (4) @(posedge clk);
  endtask

  // R1 R2: master side of one select period; pbits>0 adds a cut-short word
  task automatic spi_frame(input int nwords, input int pbits);
    cmp_en = 0;
    @(negedge clk); ss_n = 0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < nwords + (pbits > 0 ? 1 : 0); k++) begin
      int nb;
      logic [7:0] mw, got, exp_tx;
      nb = (k < nwords) ? 8 : pbits;
      mw = 8'h3C + 8'(wseed * 8'h5B);
      wseed++;
      got = '0;
      exp_tx = model_tx_load();
      for (int b = 0; b < nb; b++) begin
        if (!cpha) begin
          mosi = mw[7-b];
          repeat (H) @(negedge clk);
          sck = ~cpol; got[7-b] = miso;
          repeat (H) @(negedge clk);
          sck = cpol;
        end else begin
          sck = ~cpol; mosi = mw[7-b];
          repeat (H) @(negedge clk);
          sck = cpol; got[7-b] = miso;
          repeat (H) @(negedge clk);
        end
      end
      if (nb == 8) begin
        check(tx_en ? "R1" : "R10", "miso word", got, exp_tx);
        model_rx_word(mw);
      end
    end
    repeat (H) @(negedge clk);
    ss_n = 1;
    repeat (12) @(negedge clk);
    cmp_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sck = 0; ss_n = 1; mosi = 0; cpol = 0; cpha = 0;
    rx_en = 1; tx_en = 1; fc_en = 0; wmark = 0; ovf_pol = 0;
    rx_pop = 0; tx_push = 0; tx_data = 0; ovf_clr = 0; udr_clr = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12", "ovf_flag", {7'd0, ovf_flag}, 8'd0);
    check("R12", "udr_flag", {7'd0, udr_flag}, 8'd0);
    check("R12", "rx_req", {7'd0, rx_req}, 8'd0);
    check("R12", "rdy", {7'd0, rdy}, 8'd1);
    check("R12", "tx_req", {7'd0, tx_req}, 8'd1);
    cmp_en = 1;

    // R1 R3 mode 0, three back-to-back words
    push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
    spi_frame(3, 0);
    repeat (3) pop_rx();

    // R1 R10 mode 3, second word underruns
    set_mode(1, 1);
    push_tx(8'h5A);
    spi_frame(2, 0);
    clr_flags(0, 1);
    repeat (2) pop_rx();

    // R1 modes 2 and 1
    set_mode(1, 0); push_tx(8'h96); spi_frame(1, 0);
    set_mode(0, 1); push_tx(8'h69); spi_frame(1, 0);
    repeat (2) pop_rx();

    // R2 cut-short word is not stored but still took its tx entry
    set_mode(0, 0);
    push_tx(8'h77); push_tx(8'h88);
    spi_frame(1, 4);
    pop_rx();

    // R3 receive disabled: nothing stored, no overflow
    @(posedge clk); #1 rx_en = 0;
    spi_frame(1, 0);
    @(posedge clk); #1 rx_en = 1;
    clr_flags(0, 1);

    // R10 transmit disabled leaves the FIFO alone
    @(posedge clk); #1 tx_en = 0;
    push_tx(8'h99);
    spi_frame(1, 0);
    @(posedge clk); #1 tx_en = 1;
    spi_frame(1, 0);
    repeat (2) pop_rx();

    // R9 fill transmit FIFO, extra push ignored
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33); push_tx(8'h44); push_tx(8'h55);
    spi_frame(4, 0);
    repeat (4) pop_rx();

    // R5 watermark throttling
    @(posedge clk); #1 fc_en = 1; wmark = 2'd1;
    spi_frame(3, 0);
    pop_rx(); pop_rx();
    @(posedge clk); #1 wmark = 2'd3;
    spi_frame(3, 0);
    // R7 full with flow control: dropped
    spi_frame(1, 0);
    clr_flags(1, 1);

    // R6 R7 flow control off: drop policy, then overwrite policy
    @(posedge clk); #1 fc_en = 0; ovf_pol = 0;
    spi_frame(1, 0);
    clr_flags(1, 0);
    @(posedge clk); #1 ovf_pol = 1;
    spi_frame(1, 0);
    repeat (4) pop_rx();
    clr_flags(1, 1);
    repeat (4) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule